// File: doc/BRIEF.md
# Programmable System Interrupt Router

This block sits between a large population of peripheral interrupt lines and the nine general-purpose priority inputs of a processor core, levels 7 through 15. Every source carries a small programmable field choosing its target level and a mask bit of its own. Each level output is the OR of every asserting, unmasked source routed to that level. A status register lets the servicing routine see which sources are currently asserting, so it can find the one that raised the level.

Software programs the router through a simple word-addressed register port with a registered read path. A helper lookup also returns the lowest-numbered active source for a level chosen on an input port. This spares the handler a bit scan. After reset every source is masked, and the routing table holds a fixed default map that software may rewrite.

Top module: `sys_irq_router`

## Requirements
- R1: After reset all 29 mask bits read as 1 (masked), every level request is 0 and the lookup reports no hit (hit_valid 0).
- R2: The status word at address 1 reads back the sampled level of each source, with bit i for source i. Sources 1 and 21 to 26 are reserved and always read 0. Writes to address 1 have no effect.
- R3: Mask word at address 0 holds bit i = 1 for source i masked. A masked source never raises a level request.
- R4: An asserting, unmasked source raises lvl_req bit k, which stands for core level 7+k, two clock edges after it is applied. The bit drops two edges after the source releases.
- R5: The default routing field is the level minus 7. Sources 0, 2 and 3 go to 7. Sources 4 to 7 go to 8, 8 and 9 go to 9, 10 to 13 go to 10, and 14 to 16 go to 11. Sources 17 and 18 go to 12, 19 and 20 go to 13, 27 goes to 14 and 28 goes to 15. Reserved fields read 0.
- R6: The routing field of source n is the 4 bits at position 4*(n mod 8) of the word at address 2 + n/8, covering addresses 2 to 5. Writing a field moves the source to the new level, and the field reads back as written.
- R7: A routing field value above 8 routes the source to level 15 (lvl_req bit 8).
- R8: Several active sources on one level OR together, and the level stays asserted while any one of them stays active. Each source drives only its own level.
- R9: hit_id gives the lowest-numbered active, unmasked source routed to the level selected by sel_lvl, which uses the same encoding as a routing field. It is valid one edge after the routed state or sel_lvl settles. hit_valid is 0 when no such source exists.
- R10: Read data appears on bus_rdata on the edge where bus_rd is sampled high. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_irq | input | 29 | Peripheral interrupt levels, bit per source |
| sel_lvl | input | 4 | Level chosen for the lowest-source lookup |
| lvl_req | output | 9 | Level requests, bit k = core level 7+k |
| hit_valid | output | 1 | Lookup found an active source |
| hit_id | output | 5 | Lowest active source on the chosen level |

## Verification
The hardest case to reach is a routing field that has been reprogrammed into the saturated range above 8 while other sources still share the old level. Only a read-modify-write of a packed routing word reaches that state, and the neighbouring fields must stay intact during it. The bench keeps its own copy of every routing word. It rewrites single fields inside those words and then drives one source at a time against its own OR model. Each such step also exercises the level the source left and the lookup on the level it joined.

// File: rtl/sys_irq_router_pkg.sv
package sys_irq_router_pkg;
  localparam int SRC_N   = 29;
  localparam int LVL_N   = 9;
  localparam int FLD_W   = 4;
  localparam int BUS_DW  = 32;
  localparam int BUS_AW  = 3;

  // reserved source identifiers never raise a request
  function automatic logic is_rsvd(input int id);
    return (id == 1) || (id >= 21 && id <= 26);
  endfunction

  // reset routing field for a source (level minus seven)
  function automatic logic [FLD_W-1:0] reset_field(input int id);
    logic [FLD_W-1:0] f;
    if (is_rsvd(id))    f = 4'd0;
    else if (id <= 3)   f = 4'd0;
    else if (id <= 7)   f = 4'd1;
    else if (id <= 9)   f = 4'd2;
    else if (id <= 13)  f = 4'd3;
    else if (id <= 16)  f = 4'd4;
    else if (id <= 18)  f = 4'd5;
    else if (id <= 20)  f = 4'd6;
    else if (id == 27)  f = 4'd7;
    else                f = 4'd8;
    return f;
  endfunction

  // effective level offset: saturates at the top level
  function automatic int unsigned eff_level(input logic [FLD_W-1:0] f, input int top);
    return (int'(f) > top) ? top : int'(f);
  endfunction
endpackage

// File: rtl/sys_irq_router_regs.sv
module sys_irq_router_regs
  import sys_irq_router_pkg::*;
#(
  parameter int NSRC = SRC_N,
  parameter int FW   = FLD_W,
  parameter int DW   = BUS_DW,
  parameter int AW   = BUS_AW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic [NSRC-1:0]          status,
  output logic [DW-1:0]            rdata,
  output logic [NSRC-1:0]          mask_q,
  output logic [NSRC-1:0][FW-1:0]  route_q
);
  localparam int FPW       = DW / FW;
  localparam int RT_WORDS  = (NSRC + FPW - 1) / FPW;
  localparam int RT_BASE   = 2;
  localparam int MASK_ADR  = 0;
  localparam int STAT_ADR  = 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      for (int i = 0; i < NSRC; i++) route_q[i] <= reset_field(i);
    end else if (wr) begin
      if (int'(addr) == MASK_ADR) mask_q <= wdata[NSRC-1:0];
      for (int k = 0; k < RT_WORDS; k++) begin
        for (int j = 0; j < FPW; j++) begin
          if ((k*FPW + j) < NSRC && int'(addr) == RT_BASE + k)
            route_q[k*FPW + j] <= wdata[j*FW +: FW];
        end
      end
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (int'(addr) == MASK_ADR) rd_mux[NSRC-1:0] = mask_q;
    else if (int'(addr) == STAT_ADR) rd_mux[NSRC-1:0] = status;
    else begin
      for (int k = 0; k < RT_WORDS; k++) begin
        for (int j = 0; j < FPW; j++) begin
          if ((k*FPW + j) < NSRC && int'(addr) == RT_BASE + k)
            rd_mux[j*FW +: FW] = route_q[k*FPW + j];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  // R1: the first cycle out of reset sees every source masked
  a_r1_mask_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1));
endmodule

// File: rtl/sys_irq_router_status.sv
module sys_irq_router_status
  import sys_irq_router_pkg::*;
#(
  parameter int NSRC = SRC_N
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_irq,
  output logic [NSRC-1:0] status
);
  function automatic logic [NSRC-1:0] live_bits();
    logic [NSRC-1:0] v;
    for (int i = 0; i < NSRC; i++) v[i] = !is_rsvd(i);
    return v;
  endfunction
  localparam logic [NSRC-1:0] LIVE = live_bits();

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= src_irq & LIVE;
  end
endmodule

// File: rtl/sys_irq_router_route.sv
module sys_irq_router_route
  import sys_irq_router_pkg::*;
#(
  parameter int NSRC = SRC_N,
  parameter int NLVL = LVL_N,
  parameter int FW   = FLD_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSRC-1:0]         active,
  input  logic [NSRC-1:0]         mask_q,
  input  logic [NSRC-1:0][FW-1:0] route_q,
  output logic [NLVL-1:0]         lvl_req
);
  logic [NLVL-1:0] req_nxt;

  always_comb begin
    req_nxt = '0;
    for (int i = 0; i < NSRC; i++) begin
      for (int l = 0; l < NLVL; l++) begin
        if (eff_level(route_q[i], NLVL-1) == l && active[i]) req_nxt[l] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_req <= '0;
    else     lvl_req <= req_nxt;
  end

  // R3: with every source masked no request follows
  a_r3_all_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> (lvl_req == '0));
  // R4: a request needs an active source one cycle earlier
  a_r4_req_has_source: assert property (@(posedge clk) disable iff (rst)
    (|lvl_req) |-> $past(|active));
  // R8: each source lights at most one level
  a_r8_one_level_per_source: assert property (@(posedge clk) disable iff (rst)
    $countones(lvl_req) <= $countones($past(active)));
endmodule

// File: rtl/sys_irq_router_find.sv
module sys_irq_router_find
  import sys_irq_router_pkg::*;
#(
  parameter int NSRC = SRC_N,
  parameter int NLVL = LVL_N,
  parameter int FW   = FLD_W,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSRC-1:0]         active,
  input  logic [NSRC-1:0][FW-1:0] route_q,
  input  logic [FW-1:0]           sel_lvl,
  output logic                    hit_valid,
  output logic [IDW-1:0]          hit_id
);
  logic           found;
  logic [IDW-1:0] idx;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (active[i] && eff_level(route_q[i], NLVL-1) == eff_level(sel_lvl, NLVL-1)) begin
        found = 1'b1;
        idx   = IDW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit_id    <= '0;
    end else begin
      hit_valid <= found;
      hit_id    <= idx;
    end
  end

  // R9: a reported hit comes from an active source
  a_r9_hit_has_source: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> $past(|active));
endmodule

// File: rtl/sys_irq_router.sv
module sys_irq_router
  import sys_irq_router_pkg::*;
#(
  parameter int NSRC = SRC_N,
  parameter int NLVL = LVL_N,
  parameter int FW   = FLD_W,
  parameter int DW   = BUS_DW,
  parameter int AW   = BUS_AW,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_irq,
  input  logic [FW-1:0]   sel_lvl,
  output logic [NLVL-1:0] lvl_req,
  output logic            hit_valid,
  output logic [IDW-1:0]  hit_id
);
  logic [NSRC-1:0]         status;
  logic [NSRC-1:0]         mask_q;
  logic [NSRC-1:0][FW-1:0] route_q;
  logic [NSRC-1:0]         active;

  assign active = status & ~mask_q;

  sys_irq_router_status #(.NSRC(NSRC)) u_status (
    .clk(clk), .rst(rst), .src_irq(src_irq), .status(status));

  sys_irq_router_regs #(.NSRC(NSRC), .FW(FW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .status(status), .rdata(bus_rdata),
    .mask_q(mask_q), .route_q(route_q));

  sys_irq_router_route #(.NSRC(NSRC), .NLVL(NLVL), .FW(FW)) u_route (
    .clk(clk), .rst(rst), .active(active), .mask_q(mask_q),
    .route_q(route_q), .lvl_req(lvl_req));

  sys_irq_router_find #(.NSRC(NSRC), .NLVL(NLVL), .FW(FW)) u_find (
    .clk(clk), .rst(rst), .active(active), .route_q(route_q),
    .sel_lvl(sel_lvl), .hit_valid(hit_valid), .hit_id(hit_id));
endmodule

// File: tb/sys_irq_router_tb.sv
`timescale 1ns/1ps
module sys_irq_router_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [28:0] src_irq = 0;
  logic [3:0]  sel_lvl = 0;
  logic [8:0]  lvl_req;
  logic        hit_valid;
  logic [4:0]  hit_id;

  int checks = 0, fails = 0;
  int m_route [29];
  logic [28:0] m_mask;

  always #4 clk = ~clk;

  sys_irq_router u_dut (.*);

  function automatic bit rsvd(int id);
    return id == 1 || (id >= 21 && id <= 26);
  endfunction
  function automatic int dflt(int id);
    if (rsvd(id)) return 0;
    if (id <= 3) return 0;  if (id <= 7) return 1;  if (id <= 9) return 2;
    if (id <= 13) return 3; if (id <= 16) return 4; if (id <= 18) return 5;
    if (id <= 20) return 6; if (id == 27) return 7; return 8;
  endfunction
  function automatic int lv(int f); return f > 8 ? 8 : f; endfunction
  function automatic logic [8:0] exp_req(logic [28:0] s);
    logic [8:0] r = '0;
    for (int i = 0; i < 29; i++)
      if (s[i] && !m_mask[i] && !rsvd(i)) r[lv(m_route[i])] = 1'b1;
    return r;
  endfunction
  function automatic logic [31:0] route_word(int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 8; j++) if (k*8+j < 29) w[j*4 +: 4] = 4'(m_route[k*8+j]);
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(posedge clk); #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic drive(logic [28:0] s);
    @(negedge clk); src_irq = s;
    repeat (2) @(posedge clk); #1;
  endtask
  task automatic set_route(int id, int f);
    m_route[id] = f;
    wr(3'(2 + id/8), route_word(id/8));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 lvl_req", 32'(lvl_req), 0);
    chk("R1 hit_valid", 32'(hit_valid), 0);
    rd(0, d); chk("R1 mask", d, 32'h1FFF_FFFF);
    for (int k = 0; k < 4; k++) begin
      rd(3'(2+k), d); chk("R5 default route word", d, route_word(k));
    end
    drive('1); chk("R3 masked sources quiet", 32'(lvl_req), 0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    drive('1);
    rd(1, d); chk("R2 status all set", d, 32'h181F_FFFD);
    wr(1, 32'h0); rd(1, d); chk("R2 status write ignored", d, 32'h181F_FFFD);
    drive(29'h0000_0500); rd(1, d); chk("R2 status pattern", d, 32'h0000_0500);
    rd(6, d); chk("R10 unmapped 6", d, 0);
    rd(7, d); chk("R10 unmapped 7", d, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    m_mask = ~29'h400; wr(0, 32'(m_mask));
    rd(0, d); chk("R3 mask readback", d, 32'(m_mask));
    drive(29'h0000_0C00);
    chk("R4 only unmasked source routes", 32'(lvl_req), 32'(exp_req(29'h0000_0C00)));
    chk("R4 level 10 bit", 32'(lvl_req), 32'h8);
    drive(29'h0000_0800); chk("R3 masked source alone", 32'(lvl_req), 0);
    drive(0); chk("R4 release", 32'(lvl_req), 0);
  endtask

  task automatic t_default();
    int ids [10] = '{0, 2, 4, 8, 13, 16, 18, 20, 27, 28};
    m_mask = '0; wr(0, 0);
    foreach (ids[n]) begin
      drive(29'(1) << ids[n]);
      chk($sformatf("R5 default level src %0d", ids[n]), 32'(lvl_req), 32'(1) << dflt(ids[n]));
    end
    drive(29'h07E0_0002); chk("R2 reserved never route", 32'(lvl_req), 0);
    drive(0);
  endtask

  task automatic t_remap();
    logic [31:0] d;
    set_route(3, 5);
    rd(2, d); chk("R6 field readback", d, route_word(0));
    drive(29'h8); chk("R6 moved to level 12", 32'(lvl_req), 32'h20);
    drive(29'h9); chk("R6 neighbour kept", 32'(lvl_req), 32'(exp_req(29'h9)));
    set_route(3, 12);
    drive(29'h8); chk("R7 saturated to 15", 32'(lvl_req), 32'h100);
    set_route(17, 15);
    drive(29'h2_0008); chk("R7 two saturated", 32'(lvl_req), 32'h100);
    set_route(3, 0); set_route(17, 5);
    drive(0);
  endtask

  task automatic t_or();
    drive(29'h0000_2C00); chk("R8 shared level", 32'(lvl_req), 32'h8);
    drive(29'h0000_2800); chk("R8 one dropped", 32'(lvl_req), 32'h8);
    drive(29'h1008_0011); chk("R8 mixed levels", 32'(lvl_req), 32'(exp_req(29'h1008_0011)));
    drive(0); chk("R8 all dropped", 32'(lvl_req), 0);
  endtask

  task automatic t_find();
    @(negedge clk); sel_lvl = 3;
    drive(29'h0000_2800);
    chk("R9 hit valid", 32'(hit_valid), 1);
    chk("R9 lowest id", 32'(hit_id), 11);
    @(negedge clk); sel_lvl = 1; @(posedge clk); #1;
    chk("R9 empty level", 32'(hit_valid), 0);
    set_route(13, 9);
    @(negedge clk); sel_lvl = 14; @(posedge clk); #1; @(posedge clk); #1;
    chk("R9 saturated select id", 32'(hit_id), 13);
    chk("R9 saturated select valid", 32'(hit_valid), 1);
    drive(0); chk("R9 cleared", 32'(hit_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 29; i++) m_route[i] = dflt(i);
    m_mask = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset(); t_status(); t_mask(); t_default(); t_remap(); t_or(); t_find();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule